// File: doc/BRIEF.md
# I2C Master Command and Receive Queues

This block sits between a register port and the bus engine of an I2C master. Software feeds the engine by writing a single data/command register. Each write becomes one entry of a transmit queue. An entry is either a byte to send or a request to read one byte from the bus. The bus engine takes entries from the head of that queue. Each byte it receives goes into a second queue, and software collects the bytes by reading the same data/command register.

Both fill levels can be read through the port. Two threshold comparisons drive the conditions that raise interrupts. One reports that the transmit queue is running low; the other reports that the receive queue holds enough data. A parameter register reports the built depths so that software can size its bursts. Three sticky error flags record dropped or missing entries, and software clears them by writing ones. An abort input discards everything in both queues.

Top module: `i2c_cmd_fifos`

## Requirements
- R1: A write to word 0 with bit 8 clear queues bits 7:0 as a transmit byte. The head entry drives `cmd_valid`, `cmd_is_read` = 0 and `cmd_byte`. A cycle with `cmd_take` high and `cmd_valid` high removes the head. Entries leave in the order they were written, and `cmd_valid` is high exactly while the transmit queue is non-empty.
- R2: A write to word 0 with bit 8 set queues a read request. It appears as `cmd_is_read` = 1 with `cmd_byte` = 0, whatever bits 7:0 held.
- R3: While the receive queue is non-empty, word 0 reads the oldest received byte in bits 7:0, with the upper bits zero. A cycle with `reg_rd` high addressed to word 0 removes that byte. A cycle with `rx_push` high appends `rx_byte`.
- R4: Word 1 reads the transmit fill level and word 2 reads the receive fill level. Words 7 and above read zero.
- R5: Word 6 reads the transmit depth minus one in bits 23:16 and the receive depth minus one in bits 15:8. All other bits are zero.
- R6: Word 3 is an 8-bit read/write transmit threshold. `tx_empty_irq` is high while the transmit level is less than or equal to it.
- R7: Word 4 is an 8-bit read/write receive threshold. `rx_full_irq` is high while the receive level is greater than it, so a threshold of 0 fires on one byte.
- R8: A transmit write while the transmit queue is full drops the entry and sets flag bit 0 of word 5. This holds even if the engine takes an entry in the same cycle.
- R9: A receive read of word 0 while the receive queue is empty returns 0 and sets flag bit 2 of word 5.
- R10: An `rx_push` while the receive queue is full drops the byte and sets flag bit 1 of word 5.
- R11: `abort_flush` empties both queues by the next cycle. It overrides any push or pop in the same cycle, and those ignored operations set no flag.
- R12: The flags in word 5 stay set until software writes a one to their bit position. A flag set event in the same cycle as its clear leaves the flag set.
- R13: After synchronous reset, both levels, both thresholds and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops when addressed to word 0 |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cmd_valid | output | 1 | Transmit queue holds an entry |
| cmd_is_read | output | 1 | Head entry is a read request |
| cmd_byte | output | 8 | Head entry byte, 0 for read requests |
| cmd_take | input | 1 | Bus engine consumes the head entry |
| rx_push | input | 1 | Bus engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| abort_flush | input | 1 | Discards both queues |
| tx_empty_irq | output | 1 | Transmit level at or below threshold |
| rx_full_irq | output | 1 | Receive level above threshold |

## Verification
The bench targets the full-queue write that coincides with an engine take. A design that judged fullness after the take would accept an entry it should drop and never raise the transmit overflow flag. It also targets a flag clear that lands in the same cycle as a new overflow event; a design that let the clear win would lose that event. Further cases are a flush that arrives together with pushes, which must leave the queues empty with no flags set, and an underflow read, which must return zero rather than stale storage. Threshold edges are covered as well: receive threshold 0 must fire on the first byte, and the transmit condition must still hold when the level equals the threshold. Finally, a long stretch of mixed traffic is compared against a queue-based model on every cycle.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;

    localparam int REG_AW       = 3;
    localparam int CMD_READ_BIT = 8;

    typedef enum logic [REG_AW-1:0] {
        RA_DATA  = 3'd0,
        RA_TXLVL = 3'd1,
        RA_RXLVL = 3'd2,
        RA_TXTHR = 3'd3,
        RA_RXTHR = 3'd4,
        RA_FLAGS = 3'd5,
        RA_PARAM = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic       is_read;
        logic [7:0] data;
    } tx_entry_t;

    typedef struct packed {
        logic rx_under;
        logic rx_over;
        logic tx_over;
    } fifo_flags_t;

    localparam int TX_ENTRY_W = $bits(tx_entry_t);
    localparam int FLAGS_W    = $bits(fifo_flags_t);

    function automatic tx_entry_t decode_cmd(input logic [31:0] word);
        tx_entry_t e;
        e.is_read = word[CMD_READ_BIT];
        e.data    = word[CMD_READ_BIT] ? 8'h00 : word[7:0];
        return e;
    endfunction

    function automatic logic [31:0] depth_word(input int tx_depth, input int rx_depth);
        logic [7:0] t;
        logic [7:0] r;
        t = 8'(tx_depth - 1);
        r = 8'(rx_depth - 1);
        return {8'h00, t, r, 8'h00};
    endfunction

endpackage

// File: rtl/i2c_sync_fifo.sv
module i2c_sync_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             push_drop,
    output logic             pop_miss
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] count;
    logic             full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == LVL_W'(DEPTH));
    assign empty     = (count == '0);
    assign do_push   = push && !full && !flush;
    assign do_pop    = pop && !empty && !flush;
    assign push_drop = push && full && !flush;
    assign pop_miss  = pop && empty && !flush;
    assign head      = mem[rd_ptr];
    assign level     = count;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2c_level_cmp.sv
module i2c_level_cmp #(
    parameter int LVL_W = 4,
    parameter int THR_W = 8,
    parameter bit ABOVE = 1'b0
) (
    input  logic [LVL_W-1:0] level,
    input  logic [THR_W-1:0] thr,
    output logic             hit
);
    localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;
    logic [CW-1:0] l_ext, t_ext;

    assign l_ext = CW'(level);
    assign t_ext = CW'(thr);

    generate
        if (ABOVE) begin : g_above
            assign hit = (l_ext > t_ext);
        end else begin : g_at_or_below
            assign hit = (l_ext <= t_ext);
        end
    endgenerate
endmodule

// File: rtl/i2c_cmd_fifos.sv
module i2c_cmd_fifos
    import i2c_fifo_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int THR_W    = 8,
    localparam int TX_LVL_W = $clog2(TX_DEPTH + 1),
    localparam int RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cmd_valid,
    output logic              cmd_is_read,
    output logic [7:0]        cmd_byte,
    input  logic              cmd_take,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              abort_flush,
    output logic              tx_empty_irq,
    output logic              rx_full_irq
);
    logic                tx_wr_data, rx_rd_data;
    tx_entry_t           tx_in, tx_head;
    logic [TX_LVL_W-1:0] tx_lvl;
    logic [RX_LVL_W-1:0] rx_lvl;
    logic                tx_empty, rx_empty;
    logic [7:0]          rx_head;
    logic                tx_drop, tx_miss_unused, rx_drop, rx_miss;
    logic [THR_W-1:0]    tx_thr, rx_thr;
    fifo_flags_t         flag_q, flag_set, flag_clr;

    assign tx_wr_data = reg_wr && (reg_addr == RA_DATA);
    assign rx_rd_data = reg_rd && (reg_addr == RA_DATA);
    assign tx_in      = decode_cmd(reg_wdata);

    i2c_sync_fifo #(.WIDTH(TX_ENTRY_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(abort_flush),
        .push(tx_wr_data), .push_data(tx_in),
        .pop(cmd_take), .head(tx_head), .level(tx_lvl),
        .empty(tx_empty), .push_drop(tx_drop), .pop_miss(tx_miss_unused)
    );

    i2c_sync_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(abort_flush),
        .push(rx_push), .push_data(rx_byte),
        .pop(rx_rd_data), .head(rx_head), .level(rx_lvl),
        .empty(rx_empty), .push_drop(rx_drop), .pop_miss(rx_miss)
    );

    i2c_level_cmp #(.LVL_W(TX_LVL_W), .THR_W(THR_W), .ABOVE(1'b0)) u_tx_cmp (
        .level(tx_lvl), .thr(tx_thr), .hit(tx_empty_irq)
    );

    i2c_level_cmp #(.LVL_W(RX_LVL_W), .THR_W(THR_W), .ABOVE(1'b1)) u_rx_cmp (
        .level(rx_lvl), .thr(rx_thr), .hit(rx_full_irq)
    );

    assign cmd_valid   = !tx_empty;
    assign cmd_is_read = tx_head.is_read;
    assign cmd_byte    = tx_head.data;

    // Sticky error flags: a set in the same cycle beats a clear.
    always_comb begin
        flag_set.tx_over  = tx_drop;
        flag_set.rx_over  = rx_drop;
        flag_set.rx_under = rx_miss;
        flag_clr = (reg_wr && reg_addr == RA_FLAGS) ? fifo_flags_t'(reg_wdata[FLAGS_W-1:0])
                                                    : fifo_flags_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            tx_thr <= '0;
            rx_thr <= '0;
        end else begin
            flag_q <= (flag_q & ~flag_clr) | flag_set;
            if (reg_wr && reg_addr == RA_TXTHR) tx_thr <= reg_wdata[THR_W-1:0];
            if (reg_wr && reg_addr == RA_RXTHR) rx_thr <= reg_wdata[THR_W-1:0];
        end
    end

    always_comb begin
        case (reg_addr)
            RA_DATA:  reg_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
            RA_TXLVL: reg_rdata = 32'(tx_lvl);
            RA_RXLVL: reg_rdata = 32'(rx_lvl);
            RA_TXTHR: reg_rdata = 32'(tx_thr);
            RA_RXTHR: reg_rdata = 32'(rx_thr);
            RA_FLAGS: reg_rdata = {{(32-FLAGS_W){1'b0}}, flag_q};
            RA_PARAM: reg_rdata = depth_word(TX_DEPTH, RX_DEPTH);
            default:  reg_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/i2c_cmd_fifos_chk.sv
module i2c_cmd_fifos_chk
    import i2c_fifo_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_LVL_W = $clog2(TX_DEPTH + 1),
    localparam int RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [REG_AW-1:0]   reg_addr,
    input logic [31:0]         reg_wdata,
    input logic [31:0]         reg_rdata,
    input logic                rx_push,
    input logic                abort_flush,
    input logic [TX_LVL_W-1:0] tx_lvl,
    input logic [RX_LVL_W-1:0] rx_lvl,
    input logic [FLAGS_W-1:0]  flags
);
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(tx_lvl) <= TX_DEPTH) && (32'(rx_lvl) <= RX_DEPTH));

    // R1
    tx_step_chk: assert property (@(posedge clk) disable iff (rst)
        !abort_flush |=> (tx_lvl == $past(tx_lvl)) || (tx_lvl == $past(tx_lvl) + 1'b1)
                         || (tx_lvl + 1'b1 == $past(tx_lvl)));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        abort_flush |=> (tx_lvl == '0) && (rx_lvl == '0));

    // R8
    tx_over_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_DATA && 32'(tx_lvl) == TX_DEPTH && !abort_flush)
        |=> flags[0]);

    // R10
    rx_over_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push && 32'(rx_lvl) == RX_DEPTH && !abort_flush) |=> flags[1]);

    // R9
    rx_under_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == RA_DATA && rx_lvl == '0 && !abort_flush) |=> flags[2]);

    // R9
    rx_under_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == RA_DATA && rx_lvl == '0) |-> (reg_rdata == 32'h0));

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !(reg_wr && reg_addr == RA_FLAGS && reg_wdata[0])) |=> flags[0]);
endmodule

bind i2c_cmd_fifos i2c_cmd_fifos_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push),
    .abort_flush(abort_flush), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .flags(flag_q)
);

// File: tb/test_i2c_cmd_fifos.sv
module test_i2c_cmd_fifos;
    localparam int TXD = 8;
    localparam int RXD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0, cmd_take = 0, rx_push = 0, abort_flush = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [7:0]  rx_byte = 0;
    logic [31:0] reg_rdata;
    logic        cmd_valid, cmd_is_read, tx_empty_irq, rx_full_irq;
    logic [7:0]  cmd_byte;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    int tx_q[$];
    int rx_q[$];
    int m_txthr = 0, m_rxthr = 0, m_fl = 0;

    always #2.5 clk = ~clk;

    i2c_cmd_fifos #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_i2c_cmd_fifos (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_is_read(cmd_is_read), .cmd_byte(cmd_byte), .cmd_take(cmd_take),
        .rx_push(rx_push), .rx_byte(rx_byte), .abort_flush(abort_flush),
        .tx_empty_irq(tx_empty_irq), .rx_full_irq(rx_full_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input int a);
        case (a)
            0: return (rx_q.size() > 0) ? 32'(rx_q[0]) : 32'h0;
            1: return 32'(tx_q.size());
            2: return 32'(rx_q.size());
            3: return 32'(m_txthr);
            4: return 32'(m_rxthr);
            5: return 32'(m_fl);
            6: return ((TXD - 1) << 16) | ((RXD - 1) << 8);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R3";
            3: return "R6";
            4: return "R7";
            5: return "R12";
            6: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic compare_all();
        chk("R1", 32'(cmd_valid), 32'(tx_q.size() > 0));
        if (tx_q.size() > 0) begin
            chk("R2", 32'(cmd_is_read), 32'((tx_q[0] >> 8) & 1));
            chk("R1", 32'(cmd_byte), 32'(tx_q[0] & 255));
        end
        chk("R6", 32'(tx_empty_irq), 32'(tx_q.size() <= m_txthr));
        chk("R7", 32'(rx_full_irq), 32'(rx_q.size() > m_rxthr));
        chk(tag_of(int'(reg_addr)), reg_rdata, exp_rdata(int'(reg_addr)));
    endtask

    task automatic model_update();
        int txs, rxs, setf, clrf;
        txs  = tx_q.size();
        rxs  = rx_q.size();
        setf = 0;
        clrf = (reg_wr && reg_addr == 3'd5) ? int'(reg_wdata[2:0]) : 0;
        if (abort_flush) begin
            tx_q.delete();
            rx_q.delete();
        end else begin
            if (cmd_take && txs > 0) void'(tx_q.pop_front());
            if (reg_wr && reg_addr == 3'd0) begin
                if (txs == TXD) setf |= 1;
                else tx_q.push_back(reg_wdata[8] ? 256 : int'(reg_wdata[7:0]));
            end
            if (rx_push) begin
                if (rxs == RXD) setf |= 2;
                else rx_q.push_back(int'(rx_byte));
            end
            if (reg_rd && reg_addr == 3'd0) begin
                if (rxs == 0) setf |= 4;
                else void'(rx_q.pop_front());
            end
        end
        m_fl = (m_fl & ~clrf) | setf;
        if (reg_wr && reg_addr == 3'd3) m_txthr = int'(reg_wdata[7:0]);
        if (reg_wr && reg_addr == 3'd4) m_rxthr = int'(reg_wdata[7:0]);
    endtask

    task automatic step(input logic wr, input logic rd, input logic [2:0] a,
                        input logic [31:0] wd, input logic tk, input logic rp,
                        input logic [7:0] rb, input logic fl);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        cmd_take = tk; rx_push = rp; rx_byte = rb; abort_flush = fl;
        #1;
        compare_all();
        @(posedge clk);
        model_update();
    endtask

    task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; reg_addr = a; reg_wdata = 0;
        cmd_take = 0; rx_push = 0; rx_byte = 0; abort_flush = 0;
        #1;
        chk(tag, reg_rdata, exp);
        compare_all();
        @(posedge clk);
        model_update();
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] wd);
        step(1, 0, a, wd, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1: watchdog expired, actual running expected done");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        peek(3'd1, 32'h0, "R13");
        peek(3'd2, 32'h0, "R13");
        peek(3'd3, 32'h0, "R13");
        peek(3'd4, 32'h0, "R13");
        peek(3'd5, 32'h0, "R13");
        // R5 depth word
        peek(3'd6, 32'h0007_0700, "R5");
        peek(3'd7, 32'h0, "R4");

        // R1 / R2 ordering and read-request encoding
        wr_reg(3'd0, 32'h0000_00A5);
        wr_reg(3'd0, 32'h0000_01FF);
        wr_reg(3'd0, 32'h0000_003C);
        peek(3'd1, 32'd3, "R4");
        #1;
        chk("R1", {23'h0, cmd_is_read, cmd_byte}, 32'h0A5);
        step(0, 0, 3'd0, 0, 1, 0, 0, 0);
        #1;
        chk("R2", {23'h0, cmd_is_read, cmd_byte}, 32'h100);
        step(0, 0, 3'd0, 0, 1, 0, 0, 0);
        step(0, 0, 3'd0, 0, 1, 0, 0, 0);
        step(0, 0, 3'd0, 0, 1, 0, 0, 0);   // take while empty: no effect
        peek(3'd1, 32'd0, "R1");

        // R8 overflow, including a take in the same cycle as the dropped write
        for (int i = 0; i < TXD; i++) wr_reg(3'd0, 32'(8'h40 + i));
        step(1, 0, 3'd0, 32'h0000_0099, 1, 0, 0, 0);
        peek(3'd5, 32'h1, "R8");
        peek(3'd1, 32'd7, "R8");
        wr_reg(3'd5, 32'h1);
        peek(3'd5, 32'h0, "R12");

        // R6 threshold edges while draining
        wr_reg(3'd3, 32'd3);
        for (int i = 0; i < 8; i++) step(0, 0, 3'd1, 0, 1, 0, 0, 0);

        // R7 receive threshold 0 fires on one byte
        step(0, 0, 3'd2, 0, 0, 1, 8'h11, 0);
        #1;
        chk("R7", 32'(rx_full_irq), 32'd1);
        step(0, 0, 3'd2, 0, 0, 1, 8'h22, 0);
        step(0, 0, 3'd2, 0, 0, 1, 8'h33, 0);
        wr_reg(3'd4, 32'd2);
        #1;
        chk("R7", 32'(rx_full_irq), 32'd1);
        step(0, 1, 3'd0, 0, 0, 0, 0, 0);
        #1;
        chk("R7", 32'(rx_full_irq), 32'd0);
        step(0, 1, 3'd0, 0, 0, 0, 0, 0);
        peek(3'd0, 32'h33, "R3");
        step(0, 1, 3'd0, 0, 0, 0, 0, 0);
        // R9 underflow read
        step(0, 1, 3'd0, 0, 0, 0, 0, 0);
        peek(3'd5, 32'h4, "R9");

        // R10 receive overflow
        for (int i = 0; i < RXD + 1; i++) step(0, 0, 3'd2, 0, 0, 1, 8'(i + 1), 0);
        peek(3'd5, 32'h6, "R10");
        peek(3'd2, 32'd8, "R10");

        // R12 clear racing with a new receive overflow
        step(1, 0, 3'd5, 32'h6, 0, 1, 8'hEE, 0);
        peek(3'd5, 32'h2, "R12");
        wr_reg(3'd5, 32'h7);

        // R11 flush beats concurrent pushes and pops
        wr_reg(3'd0, 32'h55);
        step(1, 1, 3'd0, 32'h66, 1, 1, 8'h77, 1);
        peek(3'd1, 32'h0, "R11");
        peek(3'd2, 32'h0, "R11");
        peek(3'd5, 32'h0, "R11");

        // Mixed traffic against the model
        wr_reg(3'd3, 32'd2);
        wr_reg(3'd4, 32'd1);
        for (int i = 0; i < 3000; i++) begin
            logic wr, rd, tk, rp, fl;
            logic [2:0] a;
            logic [31:0] wd;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr = lfsr[0] & lfsr[3];
            rd = lfsr[1] & ~lfsr[4];
            tk = lfsr[2];
            rp = lfsr[5] & lfsr[6];
            fl = (lfsr[15:9] == 7'h55);
            a  = (lfsr[7] & lfsr[8] & lfsr[9]) ? lfsr[12:10] : 3'd0;
            if (a == 3'd3 || a == 3'd4) wd = 32'(lfsr[13:11]);
            else wd = {23'h0, lfsr[14], lfsr[15:8]};
            step(wr, rd, a, wd, tk, rp, lfsr[15:8], fl);
        end

        finish_run();
    end
endmodule